// File: doc/BRIEF.md
# Debounced Dual Empty-Voltage Detector

This block watches a stream of 8-bit battery voltage codes, one code per sample strobe, and raises two low-battery warnings. The first warning trips when the voltage falls below a programmable threshold held in a bus-writable register. The final warning trips when the voltage falls below a second threshold that sits a fixed distance under the first. Both thresholds and the sample code use the same scale: a code N stands for 1.2 V × N / 256.

A warning is raised only after a run of consecutive samples has been below its threshold, so a single noisy reading cannot trip it. Samples are expected every half second, so the default run of eight samples spans about four seconds. Once a warning is raised it stays latched until the synchronous reinitialise input is asserted. Reinitialising also clears the run counters and puts the threshold back to its power-on value.

Top module: `empty_voltage_monitor`

## Requirements
- R1: After reset, the threshold read value is 8'hA2 and both warnings are low.
- R2: The first warning rises at the clock edge that accepts the eighth consecutive valid sample whose code is strictly below the threshold register value. It does not rise on any earlier sample of the run.
- R3: A valid sample with code equal to or above a threshold restarts that warning's run from zero. Seven below, one at the threshold, then seven below leaves the warning low.
- R4: The final threshold equals the threshold register minus 21 codes, or 0 when the register is below 21. The final warning uses the same eight-sample rule against it. A code equal to the final threshold does not count, and with a final threshold of 0 the final warning never rises.
- R5: Once raised, either warning stays high while reinitialise is low, whatever codes arrive afterwards.
- R6: A bus write (`thr_wr_en` high at a clock edge) loads `thr_wr_data` into the threshold register. The read value shows it after that edge, and both trip points follow it for later samples.
- R7: Reinitialise high at a clock edge clears both warnings and both runs and restores the threshold to 8'hA2. It takes priority over a bus write and a sample at the same edge.
- R8: Cycles with the sample strobe low neither advance nor restart a run. Consecutive means consecutive strobed samples, not consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reinit | input | 1 | Synchronous reinitialise of warnings, runs and threshold |
| smp_valid | input | 1 | Sample strobe, one cycle per voltage sample |
| smp_code | input | 8 | Sampled voltage code |
| thr_wr_en | input | 1 | Threshold register write enable |
| thr_wr_data | input | 8 | Threshold register write data |
| thr_rd_data | output | 8 | Threshold register read value |
| warn_first | output | 1 | Latched first-empty warning |
| warn_final | output | 1 | Latched final-empty warning |

## Verification
The hardest case to reach is the band between the two thresholds. A code there must advance the first run and restart the final run in the same sample. This case also covers a code exactly equal to the final threshold. The stimulus reaches it by first latching the first warning with codes just under 8'hA2. It then sends codes of exactly 8'h8D, followed by a broken run of 8'h8C, so the final warning stays low until an unbroken eighth sample. Saturation of the final threshold is reached by writing a threshold below 21 and sending zero codes. Only the first warning may rise in that case.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int unsigned EVM_CODE_W     = 8;
  localparam int unsigned EVM_RUN_LEN    = 8;
  localparam int unsigned EVM_FINAL_OFS  = 21;
  localparam logic [7:0]  EVM_THR_RESET  = 8'hA2;
  localparam int unsigned EVM_NUM_LEVELS = 2;

  typedef enum logic [0:0] {
    LVL_FIRST = 1'b0,
    LVL_FINAL = 1'b1
  } evm_level_e;
endpackage

// File: rtl/evm_thresh_reg.sv
module evm_thresh_reg #(
  parameter int unsigned CODE_W    = 8,
  parameter logic [CODE_W-1:0] RESET_VAL = 8'hA2,
  parameter int unsigned OFFSET    = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] thr_first,
  output logic [CODE_W-1:0] thr_final
);
  localparam logic [CODE_W-1:0] OFS_C = CODE_W'(OFFSET);

  logic [CODE_W-1:0] thr_q;
  logic [CODE_W-1:0] thr_d;

  always_comb begin
    thr_d = thr_q;
    if (clr)        thr_d = RESET_VAL;
    else if (wr_en) thr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= RESET_VAL;
    else        thr_q <= thr_d;
  end

  // Final trip point saturates at code zero.
  always_comb begin
    if (thr_q >= OFS_C) thr_final = thr_q - OFS_C;
    else                thr_final = '0;
  end

  assign thr_first = thr_q;
endmodule

// File: rtl/evm_run_detector.sv
module evm_run_detector #(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned RUN_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [CODE_W-1:0] thr_code,
  output logic              flag
);
  localparam int unsigned CNT_W    = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             below;

  assign below = (smp_code < thr_code);

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (clr) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (smp_valid) begin
      if (!below) begin
        cnt_d = '0;
      end else if (cnt_q >= LAST_C) begin
        flag_d = 1'b1;
        cnt_d  = LAST_C;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/empty_voltage_monitor.sv
module empty_voltage_monitor
  import evm_pkg::*;
#(
  parameter int unsigned CODE_W    = EVM_CODE_W,
  parameter int unsigned RUN_LEN   = EVM_RUN_LEN,
  parameter int unsigned FINAL_OFS = EVM_FINAL_OFS,
  parameter logic [CODE_W-1:0] THR_RESET = EVM_THR_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              thr_wr_en,
  input  logic [CODE_W-1:0] thr_wr_data,
  output logic [CODE_W-1:0] thr_rd_data,
  output logic              warn_first,
  output logic              warn_final
);
  logic [CODE_W-1:0] thr_first, thr_final;
  logic [CODE_W-1:0] thr_lvl [EVM_NUM_LEVELS];
  logic [EVM_NUM_LEVELS-1:0] flags;

  evm_thresh_reg #(
    .CODE_W   (CODE_W),
    .RESET_VAL(THR_RESET),
    .OFFSET   (FINAL_OFS)
  ) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (reinit),
    .wr_en    (thr_wr_en),
    .wr_data  (thr_wr_data),
    .thr_first(thr_first),
    .thr_final(thr_final)
  );

  assign thr_lvl[LVL_FIRST] = thr_first;
  assign thr_lvl[LVL_FINAL] = thr_final;

  for (genvar g = 0; g < EVM_NUM_LEVELS; g++) begin : g_lvl
    evm_run_detector #(
      .CODE_W (CODE_W),
      .RUN_LEN(RUN_LEN)
    ) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (reinit),
      .smp_valid(smp_valid),
      .smp_code (smp_code),
      .thr_code (thr_lvl[g]),
      .flag     (flags[g])
    );
  end

  assign thr_rd_data = thr_first;
  assign warn_first  = flags[LVL_FIRST];
  assign warn_final  = flags[LVL_FINAL];
endmodule

// File: rtl/evm_checker.sv
module evm_checker #(
  parameter int unsigned CODE_W = 8,
  parameter logic [CODE_W-1:0] THR_RESET = 8'hA2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reinit,
  input logic              smp_valid,
  input logic [CODE_W-1:0] smp_code,
  input logic              thr_wr_en,
  input logic [CODE_W-1:0] thr_wr_data,
  input logic [CODE_W-1:0] thr_rd_data,
  input logic              warn_first,
  input logic              warn_final
);
  p_sticky_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_first && !reinit) |=> warn_first);

  p_sticky_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_final && !reinit) |=> warn_final);

  p_reinit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (!warn_first && !warn_final && thr_rd_data == THR_RESET));

  p_write_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_en && !reinit) |=> (thr_rd_data == $past(thr_wr_data)));

  p_rise_on_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(warn_first) || $rose(warn_final)) |-> $past(smp_valid));

  p_no_rise_at_or_above_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !reinit && !warn_first && smp_code >= thr_rd_data) |=> !warn_first);

  p_final_after_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warn_final |-> warn_first);
endmodule

bind empty_voltage_monitor evm_checker #(
  .CODE_W   (CODE_W),
  .THR_RESET(THR_RESET)
) u_evm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reinit     (reinit),
  .smp_valid  (smp_valid),
  .smp_code   (smp_code),
  .thr_wr_en  (thr_wr_en),
  .thr_wr_data(thr_wr_data),
  .thr_rd_data(thr_rd_data),
  .warn_first (warn_first),
  .warn_final (warn_final)
);

// File: tb/test_empty_voltage_monitor.sv
module test_empty_voltage_monitor;
  logic       clk;
  logic       rst_n;
  logic       reinit;
  logic       smp_valid;
  logic [7:0] smp_code;
  logic       thr_wr_en;
  logic [7:0] thr_wr_data;
  logic [7:0] thr_rd_data;
  logic       warn_first;
  logic       warn_final;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic  f1;
    logic  f2;
    string req;
  } exp_t;
  exp_t exp_q[$];

  // reference model state
  logic [7:0] m_thr;
  int         m_c1, m_c2;
  logic       m_f1, m_f2;

  empty_voltage_monitor i_empty_voltage_monitor (
    .clk        (clk),
    .rst_n      (rst_n),
    .reinit     (reinit),
    .smp_valid  (smp_valid),
    .smp_code   (smp_code),
    .thr_wr_en  (thr_wr_en),
    .thr_wr_data(thr_wr_data),
    .thr_rd_data(thr_rd_data),
    .warn_first (warn_first),
    .warn_final (warn_final)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] final_thr(input logic [7:0] t);
    return (t >= 8'd21) ? t - 8'd21 : 8'd0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reinit();
    m_thr = 8'hA2; m_c1 = 0; m_c2 = 0; m_f1 = 0; m_f2 = 0;
  endtask

  task automatic model_sample(input logic [7:0] code);
    logic [7:0] t2;
    t2 = final_thr(m_thr);
    if (code < m_thr) begin m_c1++; if (m_c1 >= 8) m_f1 = 1; end else m_c1 = 0;
    if (code < t2)    begin m_c2++; if (m_c2 >= 8) m_f2 = 1; end else m_c2 = 0;
  endtask

  // driver: one strobed sample, expected flags pushed to the scoreboard
  task automatic do_sample(input logic [7:0] code, input string req);
    exp_t it;
    @(negedge clk);
    smp_valid = 1'b1; smp_code = code;
    model_sample(code);
    @(posedge clk); #1;
    smp_valid = 1'b0;
    it.f1 = m_f1; it.f2 = m_f2; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic do_samples(input logic [7:0] code, input int n, input string req);
    for (int i = 0; i < n; i++) do_sample(code, req);
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    thr_wr_en = 1'b1; thr_wr_data = d;
    @(posedge clk); #1;
    thr_wr_en = 1'b0;
    m_thr = d;
    @(negedge clk);
    check(thr_rd_data == d, "R6", "threshold readback", thr_rd_data, d);
  endtask

  task automatic do_reinit(input bit with_wr, input bit with_smp);
    @(negedge clk);
    reinit = 1'b1;
    thr_wr_en = with_wr; thr_wr_data = 8'h33;
    smp_valid = with_smp; smp_code = 8'h00;
    @(posedge clk); #1;
    reinit = 1'b0; thr_wr_en = 1'b0; smp_valid = 1'b0;
    model_reinit();
    @(negedge clk);
    check(thr_rd_data == 8'hA2, "R7", "threshold after reinit", thr_rd_data, 8'hA2);
    check(!warn_first && !warn_final, "R7", "flags after reinit",
          {warn_first, warn_final}, 0);
  endtask

  // monitor: pops and compares one item per negedge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(warn_first == it.f1, it.req, "warn_first", warn_first, it.f1);
      check(warn_final == it.f2, it.req, "warn_final", warn_final, it.f2);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reinit = 1'b0; smp_valid = 1'b0; smp_code = 8'h00;
    thr_wr_en = 1'b0; thr_wr_data = 8'h00;
    model_reinit();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(thr_rd_data == 8'hA2, "R1", "threshold at reset", thr_rd_data, 8'hA2);
    check(!warn_first && !warn_final, "R1", "flags at reset", {warn_first, warn_final}, 0);

    // R2: code between the thresholds (0x8D..0xA1) counts for the first only
    do_samples(8'h90, 8, "R2");
    // R5: stays high with high codes
    do_samples(8'hFF, 3, "R5");

    // R4: code equal to final threshold 0x8D does not count
    do_samples(8'h8D, 9, "R4");
    // R3: broken run then full run for the final warning
    do_samples(8'h8C, 7, "R3");
    do_sample(8'h8D, "R3");
    do_samples(8'h8C, 7, "R3");
    do_sample(8'h8C, "R4");
    do_samples(8'hFF, 2, "R5");

    // R7: reinit clears everything
    do_reinit(1'b0, 1'b0);

    // R3 on first warning: 7 below, one equal, 7 below
    do_samples(8'h50, 7, "R3");
    do_sample(8'hA2, "R3");
    do_samples(8'h50, 7, "R3");

    // R8: idle cycles between samples do not break a run
    do_reinit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      do_sample(8'h20, "R8");
      repeat (3) @(negedge clk);
    end

    // R6 + R4 saturation: threshold below 21 gives a final threshold of 0
    do_reinit(1'b0, 1'b0);
    do_write(8'h10);
    do_samples(8'h00, 10, "R4");

    // R6: trip points follow a new value
    do_reinit(1'b0, 1'b0);
    do_write(8'h60);
    do_samples(8'h5F, 3, "R6");
    do_samples(8'h60, 1, "R6");
    do_samples(8'h4A, 8, "R6");

    // R7 priority over a write and a sample at the same edge
    do_reinit(1'b1, 1'b1);
    do_samples(8'h90, 7, "R7");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule